// File: doc/BRIEF.md
# Widening absolute-difference accumulate unit

This unit is a vector datapath slice. It executes the four widening absolute-difference-and-accumulate operations: signed or unsigned, each on the bottom or the top half of every wide lane. Each operation takes a 32-bit instruction word, two source vectors of narrow elements and a wide accumulator vector, all `VLEN` bits wide. The unit decodes the instruction and checks that the encoding is legal. For each wide lane it picks one narrow element from each source, widens both, forms their absolute difference and adds that to the matching accumulator lane.

An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. The updated vector appears on `result_vec` one cycle later, together with a one-cycle `result_valid` pulse. An encoding that is not recognised, or that carries the unallocated size code, raises `illegal` alongside `result_valid` and leaves `result_vec` unchanged. Register-file access, predication and exception delivery belong to the surrounding pipeline.

Top module: `wabd_acc_unit`

## Requirements
- R1: An instruction is recognised only when bits [31:24] equal 8'b01000101, bit 21 is 0 and bits [15:12] equal 4'b1100. Any other word raises `illegal` and leaves `result_vec` unchanged.
- R2: A recognised instruction whose size field (bits [23:22]) is 2'b00 raises `illegal` and leaves `result_vec` unchanged.
- R3: The size field selects the lane width. 2'b01 gives 16-bit lanes from 8-bit elements, 2'b10 gives 32-bit lanes from 16-bit elements, and 2'b11 gives 64-bit lanes from 32-bit elements. Lane i occupies bits [i*W +: W] of every vector.
- R4: Bit 10 selects the half. When it is 0, each lane uses the low narrow element of its slice of each source (element 2i). When it is 1, each lane uses the high narrow element (element 2i+1).
- R5: Bit 11 selects the extension. When it is 0, both operands are sign-extended. When it is 1, both are zero-extended. The lane then forms the absolute difference of the two extended values.
- R6: The absolute difference is added to the accumulator lane modulo 2^W. There is no saturation.
- R7: `result_valid` is high exactly in the cycle after an accepted operation. Without an accepted operation, `result_valid` is low and `result_vec` holds its value.
- R8: During reset `result_vec` is 0 and `result_valid`, `illegal` and `in_ready` are all low. `in_ready` goes high from the first edge after reset is released.
- R9: `illegal` is high only together with `result_valid`. A legal operation returns `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| instr | input | 32 | Instruction word |
| src_a | input | VLEN | First source vector (narrow elements) |
| src_b | input | VLEN | Second source vector (narrow elements) |
| acc_vec | input | VLEN | Accumulator vector (wide elements) |
| result_vec | output | VLEN | Updated destination vector |
| result_valid | output | 1 | Result or illegal response present |
| illegal | output | 1 | Operation was not a legal encoding |

## Verification
Two things can land in the same cycle: the illegal response to an operation, and the hold of the result produced by the legal operation accepted just before it. The bench provokes this by issuing operations back to back with no idle cycle between them. Random encodings, including the unallocated size code and words that do not match, are mixed in among legal operations. In the cycle an illegal operation is answered, the bench expects `illegal` high and `result_vec` still equal to the result of the most recent legal operation.

// File: rtl/wabd_pkg.sv
package wabd_pkg;

  localparam logic [7:0] OPC_HI    = 8'b0100_0101;
  localparam logic [3:0] OPC_MID   = 4'b1100;
  localparam int         NUM_SIZES = 3;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_H    = 2'b01,
    SZ_S    = 2'b10,
    SZ_D    = 2'b11
  } wabd_size_e;

  typedef struct packed {
    logic       match;
    wabd_size_e size;
    logic       uns;
    logic       top;
  } wabd_dec_t;

  function automatic logic dec_legal(input wabd_dec_t d);
    return d.match && (d.size != SZ_NONE);
  endfunction

endpackage

// File: rtl/wabd_decode.sv
module wabd_decode
  import wabd_pkg::*;
(
  input  logic [31:0] instr,
  output wabd_dec_t   dec,
  output logic        legal
);

  logic unused_reg_fields;
  assign unused_reg_fields = ^{instr[20:16], instr[9:0]};

  always_comb begin
    dec.match = (instr[31:24] == OPC_HI) && !instr[21] && (instr[15:12] == OPC_MID);
    dec.size  = wabd_size_e'(instr[23:22]);
    dec.uns   = instr[11];
    dec.top   = instr[10];
  end

  assign legal = dec_legal(dec);

endmodule

// File: rtl/wabd_lane.sv
module wabd_lane #(
  parameter int NW = 8
) (
  input  logic [2*NW-1:0] a_w,
  input  logic [2*NW-1:0] b_w,
  input  logic [2*NW-1:0] acc_w,
  input  logic            uns,
  input  logic            top,
  output logic [2*NW-1:0] res_w
);

  localparam int W  = 2 * NW;
  localparam int EW = NW + 2;

  function automatic logic [EW-1:0] widen(input logic [NW-1:0] v, input logic u);
    return {{2{~u & v[NW-1]}}, v};
  endfunction

  function automatic logic [EW-1:0] magnitude(input logic [EW-1:0] x, input logic [EW-1:0] y);
    logic [EW-1:0] d;
    d = x - y;
    return d[EW-1] ? (~d + 1'b1) : d;
  endfunction

  logic [NW-1:0] na, nb;
  logic [EW-1:0] mag;

  assign na    = top ? a_w[W-1:NW] : a_w[NW-1:0];
  assign nb    = top ? b_w[W-1:NW] : b_w[NW-1:0];
  assign mag   = magnitude(widen(na, uns), widen(nb, uns));
  assign res_w = acc_w + {{(W-EW){1'b0}}, mag};

endmodule

// File: rtl/wabd_lane_array.sv
module wabd_lane_array #(
  parameter int VLEN = 128,
  parameter int NW   = 8
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] acc_vec,
  input  logic            uns,
  input  logic            top,
  output logic [VLEN-1:0] res_vec
);

  localparam int W     = 2 * NW;
  localparam int LANES = VLEN / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wabd_lane #(.NW(NW)) u_lane (
      .a_w  (src_a[i*W +: W]),
      .b_w  (src_b[i*W +: W]),
      .acc_w(acc_vec[i*W +: W]),
      .uns  (uns),
      .top  (top),
      .res_w(res_vec[i*W +: W])
    );
  end

endmodule

// File: rtl/wabd_acc_unit.sv
module wabd_acc_unit
  import wabd_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] acc_vec,
  output logic [VLEN-1:0] result_vec,
  output logic            result_valid,
  output logic            illegal
);

  wabd_dec_t       dec;
  logic            legal_w;
  logic            fire_w;
  logic            ready_q;
  logic [VLEN-1:0] res_sz [NUM_SIZES];
  logic [VLEN-1:0] next_vec;

  wabd_decode u_dec (
    .instr(instr),
    .dec  (dec),
    .legal(legal_w)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    wabd_lane_array #(.VLEN(VLEN), .NW(8 << g)) u_arr (
      .src_a  (src_a),
      .src_b  (src_b),
      .acc_vec(acc_vec),
      .uns    (dec.uns),
      .top    (dec.top),
      .res_vec(res_sz[g])
    );
  end

  always_comb begin
    case (dec.size)
      SZ_H:    next_vec = res_sz[0];
      SZ_S:    next_vec = res_sz[1];
      SZ_D:    next_vec = res_sz[2];
      default: next_vec = result_vec;
    endcase
  end

  assign in_ready = ready_q;
  assign fire_w   = in_valid && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q      <= 1'b0;
      result_valid <= 1'b0;
      illegal      <= 1'b0;
      result_vec   <= '0;
    end else begin
      ready_q      <= 1'b1;
      result_valid <= fire_w;
      illegal      <= fire_w && !legal_w;
      if (fire_w && legal_w) result_vec <= next_vec;
    end
  end

endmodule

// File: rtl/wabd_acc_unit_chk.sv
module wabd_acc_unit_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fire_w,
  input logic            legal_w,
  input logic [31:0]     instr,
  input logic            in_ready,
  input logic [VLEN-1:0] result_vec,
  input logic            result_valid,
  input logic            illegal
);

  AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> result_valid); // R7

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_w |=> !result_valid); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_w |=> $stable(result_vec)); // R7

  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> result_vec == $past(result_vec)); // R2

  AST_NOMATCH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !(instr[31:24] == 8'h45 && !instr[21] && instr[15:12] == 4'hC)) |=> illegal); // R1

  AST_SIZE0_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && instr[23:22] == 2'b00) |=> illegal); // R2

  AST_ILLEGAL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> result_valid); // R9

  AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && legal_w) |=> !illegal); // R9

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready); // R8

endmodule

bind wabd_acc_unit wabd_acc_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fire_w      (fire_w),
  .legal_w     (legal_w),
  .instr       (instr),
  .in_ready    (in_ready),
  .result_vec  (result_vec),
  .result_valid(result_valid),
  .illegal     (illegal)
);

// File: tb/wabd_acc_unit_test.sv
module wabd_acc_unit_test;

  localparam int  VL       = 128;
  localparam time CLK_HALF = 5;
  localparam int  WDOG     = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   instr = '0;
  logic [VL-1:0] src_a = '0, src_b = '0, acc_vec = '0;
  logic [VL-1:0] result_vec;
  logic          result_valid, illegal;

  int            total = 0;
  int            bad = 0;
  logic [VL-1:0] exp_vec = '0;
  bit            done = 1'b0;

  always #CLK_HALF clk = ~clk;

  wabd_acc_unit #(.VLEN(VL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .src_a(src_a), .src_b(src_b), .acc_vec(acc_vec),
    .result_vec(result_vec), .result_valid(result_valid), .illegal(illegal)
  );

  function automatic bit ref_legal(input logic [31:0] ins);
    return ins[31:24] == 8'h45 && !ins[21] && ins[15:12] == 4'hC && ins[23:22] != 2'b00;
  endfunction

  function automatic logic [VL-1:0] ref_calc(input logic [31:0] ins,
      input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [VL-1:0] c);
    logic [VL-1:0] r;
    int nw, w, off;
    r = '0;
    nw = 8 << (int'(ins[23:22]) - 1);
    w = 2 * nw;
    off = ins[10] ? nw : 0;
    for (int i = 0; i < VL / w; i++) begin
      logic [63:0] xa, xb, xc, s;
      longint d;
      xa = '0; xb = '0; xc = '0;
      for (int k = 0; k < nw; k++) begin
        xa[k] = a[i*w + off + k];
        xb[k] = b[i*w + off + k];
      end
      for (int k = 0; k < w; k++) xc[k] = c[i*w + k];
      if (!ins[11]) begin
        for (int k = nw; k < 64; k++) begin
          xa[k] = xa[nw-1];
          xb[k] = xb[nw-1];
        end
      end
      d = longint'(xa) - longint'(xb);
      if (d < 0) d = -d;
      s = xc + 64'(d);
      for (int k = 0; k < w; k++) r[i*w + k] = s[k];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic u, input logic t);
    return {8'h45, sz, 1'b0, 5'd3, 4'hC, u, t, 5'd7, 5'd9};
  endfunction

  task automatic check(input bit ok, input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negative edge; leaves the bench at the following negative edge
  task automatic issue(input logic [31:0] ins, input logic [VL-1:0] a,
      input logic [VL-1:0] b, input logic [VL-1:0] c);
    bit lg;
    lg = ref_legal(ins);
    in_valid = 1'b1; instr = ins; src_a = a; src_b = b; acc_vec = c;
    if (lg) exp_vec = ref_calc(ins, a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    if (lg) begin
      check(result_valid && !illegal, "R7/R9 legal flags", {result_valid, illegal}, 2'b10);
      check(result_vec == exp_vec, "R3/R4/R5/R6 result", result_vec, exp_vec);
    end else begin
      check(result_valid && illegal, "R1/R2 illegal flags", {result_valid, illegal}, 2'b11);
      check(result_vec == exp_vec, "R1/R2 result held", result_vec, exp_vec);
    end
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1d5e_a7c3));
    repeat (3) @(negedge clk);
    check(result_vec == '0 && !result_valid && !illegal && !in_ready, "R8 reset state",
          {result_vec[7:0], result_valid, illegal, in_ready}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready after reset", in_ready, 1'b1);

    // R6 unsigned bottom wrap: 0xFF - 0x00 = 255 added to 0xFFFF -> 0x00FE
    issue(mk(2'b01, 1'b1, 1'b0), {VL/8{8'hFF}}, '0, {VL/16{16'hFFFF}});
    check(result_vec == {VL/16{16'h00FE}}, "R6 wrap", result_vec, {VL/16{16'h00FE}});
    // R5 signed: -128 vs 127 gives 255
    issue(mk(2'b01, 1'b0, 1'b0), {VL/8{8'h80}}, {VL/8{8'h7F}}, '0);
    check(result_vec == {VL/16{16'h00FF}}, "R5 signed extend", result_vec, {VL/16{16'h00FF}});
    // R4 top picks high element: high bytes 0x10 vs 0x03, low bytes equal
    issue(mk(2'b01, 1'b1, 1'b1), {VL/16{16'h1055}}, {VL/16{16'h0355}}, '0);
    check(result_vec == {VL/16{16'h000D}}, "R4 top half", result_vec, {VL/16{16'h000D}});
    // R3 64-bit lanes from 32-bit elements, signed extremes back to back with illegal size
    issue(mk(2'b11, 1'b0, 1'b1), {VL/64{64'h8000_0000_0000_0000}}, {VL/64{64'h7FFF_FFFF_0000_0000}}, '0);
    check(result_vec == {VL/64{64'h0000_0000_FFFF_FFFF}}, "R3 64-bit lanes", result_vec,
          {VL/64{64'h0000_0000_FFFF_FFFF}});
    issue(mk(2'b00, 1'b1, 1'b0), '1, '0, '1);
    issue(32'h0000_0000, '1, '0, '1);
    issue(mk(2'b10, 1'b1, 1'b0), {VL/32{32'h0000_FFFF}}, {VL/32{32'h0000_0001}}, {VL/32{32'h0000_0010}});

    // idle: no operation, nothing changes
    @(negedge clk);
    check(!result_valid && !illegal && result_vec == exp_vec, "R7 idle hold", result_vec, exp_vec);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ins;
      logic [VL-1:0] a, b, c;
      for (int q = 0; q < VL / 32; q++) begin
        a[q*32 +: 32] = $urandom;
        b[q*32 +: 32] = $urandom;
        c[q*32 +: 32] = $urandom;
      end
      if ($urandom_range(0, 9) == 0) ins = $urandom;
      else ins = {8'h45, 2'($urandom_range(0, 3)), 1'b0, 5'($urandom), 4'hC,
                  1'($urandom), 1'($urandom), 10'($urandom)};
      issue(ins, a, b, c);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check(!result_valid && result_vec == exp_vec, "R7 gap hold", result_vec, exp_vec);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule